// File: doc/BRIEF.md
# Self-Clocked Wakeup Packet Decoder

This block sits in the always-on part of a low-power radio receiver, after the stage that finds the start pattern of a wakeup request. No oscillator runs in this domain. Every rising edge of `sym_clk` is a strobe recovered from the received signal, and on that edge the sliced level on `half_in` is one Manchester half-symbol. The block groups the half-symbols in pairs and decodes each pair into one data bit. It then walks through three fields, most-significant bit first: an 8-bit company code, a 26-bit application identifier and a 12-bit channel field. That is 46 bits, or 92 half-symbols.

Each company-code and identifier bit is compared with the matching bit of the reference values on `company_ref` and `app_ref` as soon as it is decoded. The first mismatch, or the first pair that is not a legal Manchester symbol, ends the packet and sends a one-cycle pulse on `err_rst`. The channel field has no protection beyond the Manchester check; four of its bits select a band further downstream. When every identifier bit has matched and the last channel bit has been decoded, `wake` rises and `chan` shows the channel. `wake` stays high until it is acknowledged or the block is reset.

`arm` comes from the start-pattern detector. While `arm` is low, the decoder holds its counters at zero and ignores the line.

Top module: `wake_pkt_decoder`

## Requirements
- R1: After a synchronous active-low reset, `wake` and `err_rst` are 0 and `chan` is 0.
- R2: A pair of half-symbols 0 then 1 decodes to data 1, and a pair 1 then 0 decodes to data 0. The first half of each pair is the first half-symbol sampled after `arm` goes high.
- R3: A pair 0,0 or 1,1 makes `err_rst` high for exactly one cycle, starting right after the edge that sampled the second half. Later half-symbols are then ignored until `arm` goes low: there is no further `err_rst` pulse and no `wake`.
- R4: A company-code bit that differs from the corresponding bit of `company_ref` (bit 7 is compared first) produces the one-cycle `err_rst` pulse of R3 and aborts the packet.
- R5: An application-identifier bit that differs from the corresponding bit of `app_ref` (bit 25 first, bit 0 last) produces the `err_rst` pulse and aborts the packet. No pulse appears before the differing bit.
- R6: When the 92nd half-symbol completes a packet with no error, `wake` is high right after the edge that sampled it, and not before. At that point `chan` holds the 12-bit channel field, whose first received bit is `chan[11]`.
- R7: `wake` stays high until a cycle with `wake_ack` high, and falls after that edge. While `wake` is high, `chan` does not change, even if another valid packet is received. If `wake_ack` and an acceptance fall in the same cycle, `wake_ack` wins.
- R8: Taking `arm` low for at least one edge in the middle of a packet clears the pair phase and the bit counter. A full packet sent after `arm` rises again is then accepted.
- R9: Reset clears `wake`, `chan` and `err_rst` even while `wake` is high.
- R10: Half-symbols sampled while `arm` is low have no effect: no `err_rst` pulse and no `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sym_clk | input | 1 | Recovered symbol strobe; the only clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arm | input | 1 | High while a packet follows a found start pattern |
| half_in | input | 1 | Sliced half-symbol level, sampled on each strobe |
| company_ref | input | 8 | Expected company code |
| app_ref | input | 26 | Expected application identifier |
| wake_ack | input | 1 | Clears `wake` |
| wake | output | 1 | Request to power up the rest of the chip |
| chan | output | 12 | Channel field of the last accepted packet |
| err_rst | output | 1 | One-cycle pulse when a packet is rejected |

## Verification
Both results fall due one edge after the half-symbol that causes them. `err_rst` goes high at the strobe that samples the second half of the bad pair and falls at the next strobe. `wake` and `chan` update at the strobe that samples the final half-symbol, and `wake_ack` takes effect at the strobe that samples it. The bench drives every input on a falling edge and reads the outputs on the following falling edge. Each check therefore lands exactly one strobe after its stimulus, and the cycle before a result is checked as well: `wake` must still be low just before the last half-symbol, and `err_rst` must still be low just before the bad identifier bit.

// File: rtl/wpd_pkg.sv
// Package: shared types for the wakeup packet decoder.
// Assumes: nothing; it holds only the sequencer state encoding.
package wpd_pkg;

    // Sequencer state: listening for pairs, or halted until arm drops.
    typedef enum logic {
        SEQ_LISTEN = 1'b0,
        SEQ_HALT   = 1'b1
    } seq_state_t;

endpackage

// File: rtl/wpd_pair_assembler.sv
// Module: wpd_pair_assembler
// Groups consecutive half-symbols into pairs and decodes each pair.
// Fires on the strobe that samples the second half, giving the data bit
// and whether the pair was illegal.
// Assumes: the first half-symbol after arm rises starts a pair, and
// halt or a low arm discards a partly received pair.
module wpd_pair_assembler (
    input  logic sym_clk,
    input  logic rst_n,
    input  logic arm,
    input  logic halt,
    input  logic half_in,
    output logic pair_fire,
    output logic pair_bit,
    output logic pair_bad
);

    logic phase_q;
    logic first_q;

    // Purpose: track which half of the pair is due and hold the first half.
    always_ff @(posedge sym_clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            first_q <= 1'b0;
        end else if (!arm || halt) begin
            phase_q <= 1'b0;
            first_q <= 1'b0;
        end else begin
            if (!phase_q) begin
                first_q <= half_in;
            end
            phase_q <= ~phase_q;
        end
    end

    // Purpose: decode the pair when its second half is on the line.
    always_comb begin
        pair_fire = arm & ~halt & phase_q;
        pair_bit  = ~first_q & half_in;
        pair_bad  = ~(first_q ^ half_in);
    end

endmodule

// File: rtl/wpd_field_checker.sv
// Module: wpd_field_checker
// Counts decoded bits and checks the identifier bits against the reference
// values. Shifts in the channel field, signals acceptance on the last bit
// and pulses an error flag on the first bad pair or mismatch.
// Assumes: fields arrive MSB first in the order company, application,
// channel; arm low restarts the count.
module wpd_field_checker
    import wpd_pkg::*;
#(
    parameter int CO_W  = 8,
    parameter int APP_W = 26,
    parameter int CH_W  = 12
) (
    input  logic              sym_clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              pair_fire,
    input  logic              pair_bit,
    input  logic              pair_bad,
    input  logic [CO_W-1:0]   co_ref,
    input  logic [APP_W-1:0]  app_ref,
    output logic              halt,
    output logic              err_pulse,
    output logic              accept,
    output logic [CH_W-1:0]   chan_word
);

    localparam int ID_W  = CO_W + APP_W;
    localparam int TOTAL = ID_W + CH_W;
    localparam int IDX_W = $clog2(TOTAL);

    seq_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CH_W-1:0]   shift_q;
    logic              err_q;
    logic [ID_W-1:0]   id_ref;
    logic [ID_W-1:0]   ref_in_order;
    logic              in_id;
    logic              last_bit;
    logic              mismatch;
    logic              fail_now;

    assign id_ref = {co_ref, app_ref};

    // Reorder the references so that index 0 is the first bit received.
    for (genvar gi = 0; gi < ID_W; gi++) begin : g_ref_order
        assign ref_in_order[gi] = id_ref[ID_W-1-gi];
    end

    // Purpose: classify the current pair against field position and reference.
    always_comb begin
        in_id     = idx_q < IDX_W'(ID_W);
        last_bit  = idx_q == IDX_W'(TOTAL - 1);
        mismatch  = pair_fire & ~pair_bad & in_id
                    & (pair_bit != ref_in_order[idx_q]);
        fail_now  = pair_fire & (pair_bad | mismatch);
        accept    = pair_fire & ~pair_bad & last_bit;
        chan_word = {shift_q[CH_W-2:0], pair_bit};
    end

    // Purpose: advance the bit counter, shift the channel, register the error.
    always_ff @(posedge sym_clk) begin
        if (!rst_n) begin
            state_q <= SEQ_LISTEN;
            idx_q   <= '0;
            shift_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= fail_now;
            if (!arm) begin
                state_q <= SEQ_LISTEN;
                idx_q   <= '0;
                shift_q <= '0;
            end else if (fail_now) begin
                state_q <= SEQ_HALT;
            end else if (pair_fire) begin
                if (!in_id) begin
                    shift_q <= chan_word;
                end
                if (last_bit) begin
                    state_q <= SEQ_HALT;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign halt      = (state_q == SEQ_HALT);
    assign err_pulse = err_q;

endmodule

// File: rtl/wpd_wake_latch.sv
// Module: wpd_wake_latch
// Holds the wake request and the accepted channel until acknowledged.
// Assumes: acknowledge beats a same-cycle acceptance, and an acceptance
// while wake is already high is dropped so the channel stays stable.
module wpd_wake_latch #(
    parameter int CH_W = 12
) (
    input  logic             sym_clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CH_W-1:0]  chan_word,
    input  logic             wake_ack,
    output logic             wake,
    output logic [CH_W-1:0]  chan
);

    // Purpose: set wake and capture the channel on acceptance, clear on ack.
    always_ff @(posedge sym_clk) begin
        if (!rst_n) begin
            wake <= 1'b0;
            chan <= '0;
        end else if (wake_ack) begin
            wake <= 1'b0;
        end else if (accept && !wake) begin
            wake <= 1'b1;
            chan <= chan_word;
        end
    end

endmodule

// File: rtl/wake_pkt_decoder.sv
// Module: wake_pkt_decoder (top)
// Decodes a Manchester wakeup packet clocked only by recovered strobes.
// It checks company and application codes and presents the channel with
// a held wake request.
// Assumes: one half-symbol per sym_clk rising edge while arm is high;
// the reference inputs are static during a packet.
module wake_pkt_decoder #(
    parameter int CO_W  = 8,
    parameter int APP_W = 26,
    parameter int CH_W  = 12
) (
    input  logic             sym_clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             half_in,
    input  logic [CO_W-1:0]  company_ref,
    input  logic [APP_W-1:0] app_ref,
    input  logic             wake_ack,
    output logic             wake,
    output logic [CH_W-1:0]  chan,
    output logic             err_rst
);

    logic            pair_fire;
    logic            pair_bit;
    logic            pair_bad;
    logic            halt;
    logic            accept;
    logic [CH_W-1:0] chan_word;

    wpd_pair_assembler u_pair (
        .sym_clk   (sym_clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .halt      (halt),
        .half_in   (half_in),
        .pair_fire (pair_fire),
        .pair_bit  (pair_bit),
        .pair_bad  (pair_bad)
    );

    wpd_field_checker #(
        .CO_W  (CO_W),
        .APP_W (APP_W),
        .CH_W  (CH_W)
    ) u_fields (
        .sym_clk   (sym_clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .pair_fire (pair_fire),
        .pair_bit  (pair_bit),
        .pair_bad  (pair_bad),
        .co_ref    (company_ref),
        .app_ref   (app_ref),
        .halt      (halt),
        .err_pulse (err_rst),
        .accept    (accept),
        .chan_word (chan_word)
    );

    wpd_wake_latch #(
        .CH_W (CH_W)
    ) u_wake (
        .sym_clk   (sym_clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .chan_word (chan_word),
        .wake_ack  (wake_ack),
        .wake      (wake),
        .chan      (chan)
    );

endmodule

// File: rtl/wpd_checker.sv
// Module: wpd_checker
// Protocol properties on the decoder's ports, bound to the top module.
// Assumes: sampling on sym_clk with the synchronous active-low reset.
module wpd_checker #(
    parameter int CH_W = 12
) (
    input logic            sym_clk,
    input logic            rst_n,
    input logic            arm,
    input logic            wake_ack,
    input logic            wake,
    input logic [CH_W-1:0] chan,
    input logic            err_rst
);

    // R3: an error is a single-cycle pulse.
    a_r3_err_single: assert property (@(posedge sym_clk) disable iff (!rst_n)
        err_rst |=> !err_rst);

    // R3: a rejected packet never also wakes in the same cycle.
    a_r3_err_not_wake: assert property (@(posedge sym_clk) disable iff (!rst_n)
        err_rst |-> !$rose(wake));

    // R7: wake holds while it is not acknowledged.
    a_r7_wake_hold: assert property (@(posedge sym_clk) disable iff (!rst_n)
        (wake && !wake_ack) |=> wake);

    // R7: acknowledge clears wake at the next edge.
    a_r7_ack_clears: assert property (@(posedge sym_clk) disable iff (!rst_n)
        wake_ack |=> !wake);

    // R7: the channel is frozen while wake is high.
    a_r7_chan_stable: assert property (@(posedge sym_clk) disable iff (!rst_n)
        wake |=> $stable(chan));

    // R10: nothing is decoded while arm is low.
    a_r10_disarmed_quiet: assert property (@(posedge sym_clk) disable iff (!rst_n)
        !arm |=> (!err_rst && !$rose(wake)));

endmodule

bind wake_pkt_decoder wpd_checker #(.CH_W(CH_W)) u_wpd_checker (
    .sym_clk  (sym_clk),
    .rst_n    (rst_n),
    .arm      (arm),
    .wake_ack (wake_ack),
    .wake     (wake),
    .chan     (chan),
    .err_rst  (err_rst)
);

// File: tb/sim_wake_pkt_decoder.sv
`timescale 1ns/1ps
module sim_wake_pkt_decoder;

    localparam logic [7:0]  CO  = 8'hA5;
    localparam logic [25:0] APP = 26'h2C35A1F;

    logic        sym_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        half_in = 1'b0;
    logic        wake_ack = 1'b0;
    logic        wake;
    logic [11:0] chan;
    logic        err_rst;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 sym_clk = ~sym_clk;

    wake_pkt_decoder u0 (
        .sym_clk     (sym_clk),
        .rst_n       (rst_n),
        .arm         (arm),
        .half_in     (half_in),
        .company_ref (CO),
        .app_ref     (APP),
        .wake_ack    (wake_ack),
        .wake        (wake),
        .chan        (chan),
        .err_rst     (err_rst)
    );

    function automatic logic [45:0] mk(input logic [7:0] co, input logic [25:0] app,
                                       input logic [11:0] ch);
        return {co, app, ch};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All drive tasks start and end on a falling edge.
    task automatic push(input logic b);
        half_in = b;
        @(negedge sym_clk);
    endtask

    // Sends bits with index lo..hi; index 0 is the first bit on air (w[45]).
    task automatic send_bits(input logic [45:0] w, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) begin
            push(~w[45-i]);
            push(w[45-i]);
        end
    endtask

    task automatic disarm();
        arm = 1'b0;
        @(negedge sym_clk);
    endtask

    task automatic ack();
        wake_ack = 1'b1;
        @(negedge sym_clk);
        wake_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge sym_clk);
        rst_n = 1'b1;
        @(negedge sym_clk);
        check(wake == 1'b0, "R1 wake", 32'(wake), 0);
        check(err_rst == 1'b0, "R1 err_rst", 32'(err_rst), 0);
        check(chan == 12'h0, "R1 chan", 32'(chan), 0);
    endtask

    task automatic t_good();
        logic [45:0] w;
        w = mk(CO, APP, 12'hB37);
        arm = 1'b1;
        send_bits(w, 0, 44);
        push(~w[0]);
        check(wake == 1'b0, "R6 wake early", 32'(wake), 0);
        push(w[0]);
        check(wake == 1'b1, "R6 wake", 32'(wake), 1);
        check(chan == 12'hB37, "R2 R6 chan", 32'(chan), 32'hB37);
        check(err_rst == 1'b0, "R6 no err", 32'(err_rst), 0);
        disarm();
    endtask

    task automatic t_hold_ack();
        arm = 1'b1;
        send_bits(mk(CO, APP, 12'h4C1), 0, 45);
        check(wake == 1'b1, "R7 wake held", 32'(wake), 1);
        check(chan == 12'hB37, "R7 chan frozen", 32'(chan), 32'hB37);
        disarm();
        ack();
        check(wake == 1'b0, "R7 ack clears", 32'(wake), 0);
        arm = 1'b1;
        send_bits(mk(CO, APP, 12'h4C1), 0, 45);
        check(wake == 1'b1 && chan == 12'h4C1, "R2 second channel", 32'(chan), 32'h4C1);
        disarm();
        ack();
    endtask

    task automatic t_illegal(input logic lvl, input int at, input string req);
        logic [45:0] w;
        w = mk(CO, APP, 12'h5AA);
        arm = 1'b1;
        send_bits(w, 0, at - 1);
        push(lvl);
        check(err_rst == 1'b0, req, 32'(err_rst), 0);
        push(lvl);
        check(err_rst == 1'b1, req, 32'(err_rst), 1);
        push(1'b0);
        check(err_rst == 1'b0, req, 32'(err_rst), 0);
        push(1'b1);
        send_bits(w, at + 2, 45);
        check(wake == 1'b0 && err_rst == 1'b0, req, 32'(wake), 0);
        disarm();
    endtask

    task automatic t_mismatch(input logic [45:0] w, input int at, input string req);
        arm = 1'b1;
        send_bits(w, 0, at - 1);
        check(err_rst == 1'b0, req, 32'(err_rst), 0);
        send_bits(w, at, at);
        check(err_rst == 1'b1, req, 32'(err_rst), 1);
        send_bits(w, at + 1, 45);
        check(wake == 1'b0 && err_rst == 1'b0, req, 32'(wake), 0);
        disarm();
    endtask

    task automatic t_restart();
        logic [45:0] w;
        w = mk(CO, APP, 12'h9E2);
        arm = 1'b1;
        send_bits(w, 0, 19);
        push(1'b0);
        disarm();
        arm = 1'b1;
        send_bits(w, 0, 45);
        check(wake == 1'b1 && chan == 12'h9E2, "R8 restart", 32'(chan), 32'h9E2);
        disarm();
    endtask

    task automatic t_disarmed();
        logic [45:0] w;
        w = mk(CO, APP, 12'h123);
        arm = 1'b0;
        push(1'b1);
        push(1'b1);
        check(err_rst == 1'b0, "R10 no err", 32'(err_rst), 0);
        send_bits(w, 0, 45);
        check(wake == 1'b0, "R10 no wake", 32'(wake), 0);
    endtask

    task automatic t_reset_clears();
        arm = 1'b1;
        send_bits(mk(CO, APP, 12'hFFF), 0, 45);
        check(wake == 1'b1, "R9 setup", 32'(wake), 1);
        disarm();
        rst_n = 1'b0;
        @(negedge sym_clk);
        rst_n = 1'b1;
        check(wake == 1'b0 && chan == 12'h0, "R9 reset clears", 32'(chan), 0);
    endtask

    initial begin
        t_reset();
        t_good();
        t_hold_ack();
        t_illegal(1'b0, 3, "R3 pair 00");
        t_illegal(1'b1, 40, "R3 pair 11");
        t_mismatch(mk(CO ^ 8'h80, APP, 12'h777), 0, "R4 company");
        t_mismatch(mk(CO, APP ^ 26'h1, 12'h777), 33, "R5 app last bit");
        t_restart();
        ack();
        t_disarmed();
        t_reset_clears();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sym_clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule